// File: doc/BRIEF.md
# Supply Ramp Profile PWM Sequencer

This block drives a pulse-width-modulated output whose duty level traces a repeating supply-voltage profile. An external switch-mode stage filters the pulse train into an emulated pad supply, so the profile becomes a real voltage waveform. The supply can start at a non-zero level and then be ramped up, held, ramped down and held off again. Slow and fast ramps can be exercised from the same hardware without changing anything but configuration.

Software or a test sequencer loads a start level, a final level and five phase lengths through a small write-only register port while the block is idle, then pulses `start`. The block holds the start level for a settle interval and ramps linearly to the final level. It holds there, ramps back to the start level and holds again, and then loops to the ramp-up phase until `stop` is pulsed. All phase lengths are counted in whole PWM periods of `2**DUTY_W` clocks. With the default 8-bit duty and a 24 MHz clock, one period is about 10.7 us, so the 16-bit length registers reach ramp and hold times from a few tens of microseconds to several hundred milliseconds.

Top module: `ramp_pwm_seq`

## Requirements
- R1: After reset, `phase` is 0, `pwm_out` is low and `phase_evt` is low.
- R2: `phase` codes are idle=0, settle=1, ramp-up=2, on-hold=3, ramp-down=4, off-hold=5. A start from idle enters settle. The phases then run 1,2,3,4,5 and loop from 5 back to 2, never to 1. Each phase lasts as many PWM periods as its length register holds, and a length of 0 acts as 1.
- R3: A PWM period is `2**DUTY_W` clocks, the first one beginning in the cycle after the start pulse. In each period `pwm_out` is high for exactly the first D cycles and low for the rest, where D is the duty level of that period.
- R4: The duty level is the start level in every settle and off-hold period, and the final level in every on-hold period.
- R5: For a ramp of N periods (N = length, 0 acting as 1), let step = floor(|final − start| · 2^FRAC / N). In ramp-up period k (1 ≤ k < N), the level is floor((start·2^FRAC ± k·step) / 2^FRAC), where the sign moves toward the final level. In period N the level is exactly the final level. Ramp-down works the same way from the final level toward the start level, using its own length. This holds in both directions, including a final level below the start level.
- R6: The duty level changes only at a PWM period boundary, or when the sequencer leaves idle.
- R7: `phase_evt` is high for exactly one cycle, the first cycle in which `phase` shows a new value. This includes entering settle and returning to idle, and `phase_evt` is low at all other times.
- R8: A `stop` pulse makes `phase` 0 and `pwm_out` low from the next cycle, and they stay so until the next start. `stop` takes priority over a simultaneous `start` and over a phase change due in the same cycle.
- R9: Configuration writes go by `cfg_addr`: 0 start level, 1 final level (both from the low DUTY_W bits of `cfg_wdata`), 2 settle length, 3 ramp-up length, 4 on-hold length, 5 ramp-down length, 6 off-hold length. Levels reset to 0 and lengths to 1. A write is taken only while `phase` is 0 and `start` is low; otherwise it is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | TIME_W (16) | Configuration write data |
| start | input | 1 | Start pulse, taken in idle only |
| stop | input | 1 | Stop pulse, returns to idle |
| pwm_out | output | 1 | PWM carrier for the power stage |
| phase | output | 3 | Current profile phase code |
| phase_evt | output | 1 | One-cycle marker of a phase change |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a stop pulse and the period-boundary tick that would move the profile to its next phase. The bench raises `stop` in the last cycle of a one-period settle phase and expects idle, not ramp-up, together with a single `phase_evt` and a low output. The second pair is a configuration write and a start pulse. The bench issues both together, then reads the start level back through the duty of the first settle period, across a restart, to confirm that the write was dropped. A later idle write is shown to take effect.

// File: rtl/rps_pkg.sv
package rps_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_SETTLE = 3'd1,
      PH_RISE   = 3'd2,
      PH_ON     = 3'd3,
      PH_FALL   = 3'd4,
      PH_OFF    = 3'd5
   } phase_e;

   localparam int unsigned CFG_ADDR_W = 3;
   localparam logic [CFG_ADDR_W-1:0] A_LVL_START = 3'd0;
   localparam logic [CFG_ADDR_W-1:0] A_LVL_FINAL = 3'd1;
   // length registers sit at address = phase code + 1

   function automatic phase_e phase_after(phase_e p);
      case (p)
         PH_IDLE:   return PH_SETTLE;
         PH_SETTLE: return PH_RISE;
         PH_RISE:   return PH_ON;
         PH_ON:     return PH_FALL;
         PH_FALL:   return PH_OFF;
         PH_OFF:    return PH_RISE;
         default:   return PH_IDLE;
      endcase
   endfunction

endpackage

// File: rtl/rps_cfg_regs.sv
module rps_cfg_regs
   import rps_pkg::*;
#(
   parameter int unsigned DUTY_W = 8,
   parameter int unsigned TIME_W = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [CFG_ADDR_W-1:0]      wr_addr,
   input  logic [TIME_W-1:0]          wr_data,
   input  logic                       lock,
   output logic [DUTY_W-1:0]          lvl_start,
   output logic [DUTY_W-1:0]          lvl_final,
   output logic [7:0][TIME_W-1:0]     len
);

   logic wr_ok;
   assign wr_ok = wr_en && !lock;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_start <= '0;
         lvl_final <= '0;
      end else if (wr_ok) begin
         if (wr_addr == A_LVL_START) lvl_start <= wr_data[DUTY_W-1:0];
         if (wr_addr == A_LVL_FINAL) lvl_final <= wr_data[DUTY_W-1:0];
      end
   end

   // one length register per timed phase; codes without a phase read as 1
   for (genvar i = 0; i < 8; i++) begin : g_len
      if (i >= 1 && i <= 5) begin : g_reg
         logic [TIME_W-1:0] len_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               len_q <= TIME_W'(1);
            else if (wr_ok && wr_addr == CFG_ADDR_W'(i + 1))
               len_q <= wr_data;
         end
         assign len[i] = len_q;
      end else begin : g_fixed
         assign len[i] = TIME_W'(1);
      end
   end

endmodule

// File: rtl/rps_phase_seq.sv
module rps_phase_seq
   import rps_pkg::*;
#(
   parameter int unsigned TIME_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic                    stop,
   input  logic                    tick,
   input  logic [7:0][TIME_W-1:0]  len,
   output phase_e                  phase,
   output logic                    phase_evt,
   output phase_e                  phase_nxt,
   output logic                    last_nxt,
   output logic                    launch
);

   logic [TIME_W-1:0] rem_q, rem_n;
   phase_e            phase_n;

   function automatic logic [TIME_W-1:0] eff_len(input logic [TIME_W-1:0] x);
      return (x == '0) ? TIME_W'(1) : x;
   endfunction

   always_comb begin
      phase_n = phase;
      rem_n   = rem_q;
      launch  = start && !stop && (phase == PH_IDLE);
      if (stop) begin
         phase_n = PH_IDLE;
      end else if (launch) begin
         phase_n = PH_SETTLE;
         rem_n   = eff_len(len[PH_SETTLE]);
      end else if (tick && phase != PH_IDLE) begin
         if (rem_q == TIME_W'(1)) begin
            phase_n = phase_after(phase);
            rem_n   = eff_len(len[phase_n]);
         end else begin
            rem_n = rem_q - TIME_W'(1);
         end
      end
   end

   assign phase_nxt = phase_n;
   assign last_nxt  = (rem_n == TIME_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         rem_q     <= '0;
         phase_evt <= 1'b0;
      end else begin
         phase     <= phase_n;
         rem_q     <= rem_n;
         phase_evt <= (phase_n != phase);
      end
   end

endmodule

// File: rtl/rps_duty_ramp.sv
module rps_duty_ramp
   import rps_pkg::*;
#(
   parameter int unsigned DUTY_W = 8,
   parameter int unsigned FRAC   = 12,
   parameter int unsigned TIME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               launch,
   input  logic               tick,
   input  phase_e             phase_nxt,
   input  logic               last_nxt,
   input  logic [DUTY_W-1:0]  lvl_start,
   input  logic [DUTY_W-1:0]  lvl_final,
   input  logic [TIME_W-1:0]  len_rise,
   input  logic [TIME_W-1:0]  len_fall,
   output logic [DUTY_W-1:0]  duty
);

   localparam int unsigned ACC_W = DUTY_W + FRAC;
   localparam int unsigned DIV_W = (ACC_W > TIME_W) ? ACC_W : TIME_W;

   logic              upward;
   logic [DUTY_W-1:0] mag;
   assign upward = (lvl_final >= lvl_start);
   assign mag    = upward ? (lvl_final - lvl_start) : (lvl_start - lvl_final);

   logic [1:0][TIME_W-1:0] span;
   logic [1:0][ACC_W-1:0]  step_w;
   assign span[0] = len_rise;
   assign span[1] = len_fall;

   // one step divider per ramp direction, sampled once at launch
   for (genvar g = 0; g < 2; g++) begin : g_step
      logic [DIV_W-1:0] num, den, quo;
      assign num = DIV_W'(mag) << FRAC;
      assign den = (span[g] == '0) ? DIV_W'(1) : DIV_W'(span[g]);
      assign quo = num / den;
      assign step_w[g] = ACC_W'(quo);
   end

   logic [ACC_W-1:0]      acc_q;
   logic [1:0][ACC_W-1:0] step_q;
   logic                  up_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         step_q <= '0;
         up_q   <= 1'b1;
      end else if (launch) begin
         acc_q  <= ACC_W'(lvl_start) << FRAC;
         step_q <= step_w;
         up_q   <= upward;
      end else if (tick) begin
         case (phase_nxt)
            PH_RISE: acc_q <= last_nxt ? (ACC_W'(lvl_final) << FRAC)
                              : (up_q ? acc_q + step_q[0] : acc_q - step_q[0]);
            PH_FALL: acc_q <= last_nxt ? (ACC_W'(lvl_start) << FRAC)
                              : (up_q ? acc_q - step_q[1] : acc_q + step_q[1]);
            default: ;
         endcase
      end
   end

   assign duty = acc_q[ACC_W-1:FRAC];

endmodule

// File: rtl/rps_pwm_carrier.sv
module rps_pwm_carrier #(
   parameter int unsigned DUTY_W  = 8,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               active,
   input  logic               run,
   input  logic [DUTY_W-1:0]  duty,
   output logic [DUTY_W-1:0]  cnt,
   output logic               tick,
   output logic               pwm
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (!run) cnt <= '0;
      else          cnt <= cnt + DUTY_W'(1);
   end

   assign tick = run && (cnt == '1);

   if (OUT_REG) begin : g_reg_out
      logic pwm_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pwm_q <= 1'b0;
         else        pwm_q <= active && (cnt < duty);
      end
      assign pwm = pwm_q;
   end else begin : g_comb_out
      assign pwm = active && (cnt < duty);
   end

endmodule

// File: rtl/ramp_pwm_seq.sv
module ramp_pwm_seq
   import rps_pkg::*;
#(
   parameter int unsigned DUTY_W  = 8,
   parameter int unsigned FRAC    = 12,
   parameter int unsigned TIME_W  = 16,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_addr,
   input  logic [TIME_W-1:0] cfg_wdata,
   input  logic              start,
   input  logic              stop,
   output logic              pwm_out,
   output logic [2:0]        phase,
   output logic              phase_evt
);

   if (DUTY_W < 2 || DUTY_W > 16) begin : g_bad_duty_w
      $error("ramp_pwm_seq: DUTY_W must lie in 2..16");
   end
   if (FRAC < 1 || FRAC > 24) begin : g_bad_frac
      $error("ramp_pwm_seq: FRAC must lie in 1..24");
   end
   if (TIME_W < DUTY_W || TIME_W > 32) begin : g_bad_time_w
      $error("ramp_pwm_seq: TIME_W must lie in DUTY_W..32");
   end

   logic [DUTY_W-1:0]      lvl_start_w, lvl_final_w, duty_w, cnt_w;
   logic [7:0][TIME_W-1:0] len_w;
   phase_e                 ph_w, ph_nxt_w;
   logic                   last_nxt_w, launch_w, tick_w, active_w, cfg_lock_w;

   assign active_w   = (ph_w != PH_IDLE);
   assign cfg_lock_w = active_w || start;

   rps_cfg_regs #(.DUTY_W(DUTY_W), .TIME_W(TIME_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_addr),
      .wr_data(cfg_wdata), .lock(cfg_lock_w),
      .lvl_start(lvl_start_w), .lvl_final(lvl_final_w), .len(len_w)
   );

   rps_phase_seq #(.TIME_W(TIME_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .tick(tick_w),
      .len(len_w), .phase(ph_w), .phase_evt(phase_evt),
      .phase_nxt(ph_nxt_w), .last_nxt(last_nxt_w), .launch(launch_w)
   );

   rps_duty_ramp #(.DUTY_W(DUTY_W), .FRAC(FRAC), .TIME_W(TIME_W)) u_ramp (
      .clk(clk), .rst_n(rst_n), .launch(launch_w), .tick(tick_w),
      .phase_nxt(ph_nxt_w), .last_nxt(last_nxt_w),
      .lvl_start(lvl_start_w), .lvl_final(lvl_final_w),
      .len_rise(len_w[PH_RISE]), .len_fall(len_w[PH_FALL]), .duty(duty_w)
   );

   rps_pwm_carrier #(.DUTY_W(DUTY_W), .OUT_REG(OUT_REG)) u_pwm (
      .clk(clk), .rst_n(rst_n), .active(active_w), .run(active_w && !stop),
      .duty(duty_w), .cnt(cnt_w), .tick(tick_w), .pwm(pwm_out)
   );

   assign phase = ph_w;

endmodule

// File: rtl/rps_chk.sv
module rps_chk #(
   parameter int unsigned DUTY_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stop,
   input logic [2:0]        phase,
   input logic              phase_evt,
   input logic              pwm_out,
   input logic [DUTY_W-1:0] duty,
   input logic [DUTY_W-1:0] cnt,
   input logic [DUTY_W-1:0] lvl_start,
   input logic [DUTY_W-1:0] lvl_final
);

   logic [DUTY_W-1:0] lvl_lo, lvl_hi;
   assign lvl_lo = (lvl_start < lvl_final) ? lvl_start : lvl_final;
   assign lvl_hi = (lvl_start < lvl_final) ? lvl_final : lvl_start;

   p_phase_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
      phase <= 3'd5);

   p_phase_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != $past(phase) && phase != 3'd0) |->
         (($past(phase) == 3'd0 && phase == 3'd1) ||
          ($past(phase) == 3'd1 && phase == 3'd2) ||
          ($past(phase) == 3'd2 && phase == 3'd3) ||
          ($past(phase) == 3'd3 && phase == 3'd4) ||
          ($past(phase) == 3'd4 && phase == 3'd5) ||
          ($past(phase) == 3'd5 && phase == 3'd2)));

   p_duty_in_span_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != 3'd0) |-> (duty >= lvl_lo && duty <= lvl_hi));

   p_duty_at_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (duty != $past(duty)) |-> ($past(cnt) == '1 || $past(phase) == 3'd0));

   p_evt_on_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != $past(phase)) |-> phase_evt);

   p_evt_only_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
      phase_evt |-> (phase != $past(phase)));

   p_stop_to_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> (phase == 3'd0));

   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 3'd0 && $past(phase) == 3'd0) |-> !pwm_out);

endmodule

bind ramp_pwm_seq rps_chk #(.DUTY_W(DUTY_W)) u_rps_chk (
   .clk(clk), .rst_n(rst_n), .stop(stop), .phase(phase),
   .phase_evt(phase_evt), .pwm_out(pwm_out), .duty(duty_w), .cnt(cnt_w),
   .lvl_start(lvl_start_w), .lvl_final(lvl_final_w)
);

// File: tb/ramp_pwm_seq_test.sv
`timescale 1ns/1ps
module ramp_pwm_seq_test;

   localparam int DW  = 4;
   localparam int FW  = 4;
   localparam int TW  = 8;
   localparam int PER = 1 << DW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_addr = '0;
   logic [TW-1:0] cfg_wdata = '0;
   logic          start = 1'b0;
   logic          stop = 1'b0;
   logic          pwm_out;
   logic [2:0]    phase;
   logic          phase_evt;

   int  n_run = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #2 clk = ~clk;

   ramp_pwm_seq #(.DUTY_W(DW), .FRAC(FW), .TIME_W(TW)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .start(start), .stop(stop),
      .pwm_out(pwm_out), .phase(phase), .phase_evt(phase_evt)
   );

   task automatic chk(string req, string what, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wr(int a, int d);
      cfg_we    = 1'b1;
      cfg_addr  = a[2:0];
      cfg_wdata = d[TW-1:0];
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   function automatic int eff(int x);
      return (x == 0) ? 1 : x;
   endfunction

   // count high cycles over one period starting at the current sample point
   task automatic measure(output int hi, output int gap, output int evs);
      hi = 0; gap = 0; evs = 0;
      for (int c = 0; c < PER; c++) begin
         if (pwm_out) begin
            hi++;
            if (hi != c + 1) gap = 1;
         end
         evs += int'(phase_evt);
         @(negedge clk);
      end
   endtask

   task automatic do_stop();
      int hi, gap, evs;
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      chk("R8", "phase after stop", int'(phase), 0);
      chk("R7", "evt on return to idle", int'(phase_evt), 1);
      chk("R8", "pwm after stop", int'(pwm_out), 0);
      @(negedge clk);
      measure(hi, gap, evs);
      chk("R8", "high cycles while idle", hi, 0);
      chk("R8", "phase stays idle", int'(phase), 0);
   endtask

   task automatic run_profile(int v1, int v2, int ls, int lr, int lo, int lf, int lx, int np);
      int len [6];
      int ph, rem, acc, incu, incd, mag, prev;
      int hi, gap, evs, ph_s, ev0;
      bit up;
      len[0] = 1; len[1] = eff(ls); len[2] = eff(lr);
      len[3] = eff(lo); len[4] = eff(lf); len[5] = eff(lx);
      wr(0, v1); wr(1, v2); wr(2, ls); wr(3, lr); wr(4, lo); wr(5, lf); wr(6, lx);
      up   = (v2 >= v1);
      mag  = up ? (v2 - v1) : (v1 - v2);
      incu = (mag << FW) / len[2];
      incd = (mag << FW) / len[4];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      ph = 1; rem = len[1]; acc = v1 << FW; prev = 0;
      for (int p = 0; p < np; p++) begin
         if (p > 0) begin
            prev = ph;
            if (rem == 1) begin
               ph  = (ph == 5) ? 2 : ph + 1;
               rem = len[ph];
            end else begin
               rem--;
            end
            if (ph == 2)
               acc = (rem == 1) ? (v2 << FW) : (up ? acc + incu : acc - incu);
            else if (ph == 4)
               acc = (rem == 1) ? (v1 << FW) : (up ? acc - incd : acc + incd);
         end
         ph_s = int'(phase);
         ev0  = int'(phase_evt);
         measure(hi, gap, evs);
         chk("R2", "phase code in period", ph_s, ph);
         chk((ph == 2 || ph == 4) ? "R5" : "R4", "duty high cycles", hi, acc >> FW);
         chk("R3", "high run not at period start", gap, 0);
         chk("R7", "evt in first cycle", ev0, int'(ph != prev));
         chk("R7", "evt count in period", evs, int'(ph != prev));
      end
      do_stop();
   endtask

   initial begin
      int hi, gap, evs;
      int lv1 [3] = '{0, 5, 15};
      int lv2 [3] = '{0, 7, 15};
      int lrs [3] = '{1, 3, 7};
      int lfs [2] = '{2, 5};

      repeat (3) @(negedge clk);
      chk("R1", "phase in reset", int'(phase), 0);
      chk("R1", "pwm in reset", int'(pwm_out), 0);
      chk("R1", "evt in reset", int'(phase_evt), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "phase after reset", int'(phase), 0);
      chk("R1", "pwm after reset", int'(pwm_out), 0);

      // sweep of levels and ramp lengths, both directions
      foreach (lv1[a]) foreach (lv2[b]) foreach (lrs[c]) foreach (lfs[d]) begin
         run_profile(lv1[a], lv2[b], 2, lrs[c], 1, lfs[d], 2,
                     2 + 2 * (lrs[c] + 1 + lfs[d] + 2) + 1);
      end

      // zero lengths act as one period (R2)
      run_profile(3, 12, 0, 0, 0, 0, 0, 9);
      run_profile(14, 2, 1, 4, 3, 3, 1, 20);

      // stop on the cycle that would end settle (R8)
      wr(0, 4); wr(1, 10); wr(2, 1); wr(3, 2);
      start = 1'b1; @(negedge clk); start = 1'b0;
      repeat (PER - 1) @(negedge clk);
      stop = 1'b1; @(negedge clk); stop = 1'b0;
      chk("R8", "stop beats phase boundary", int'(phase), 0);
      chk("R7", "single evt at stop on boundary", int'(phase_evt), 1);
      chk("R8", "pwm low after boundary stop", int'(pwm_out), 0);
      @(negedge clk);
      chk("R7", "evt drops after one cycle", int'(phase_evt), 0);

      // start and stop together in idle (R8)
      start = 1'b1; stop = 1'b1; @(negedge clk); start = 1'b0; stop = 1'b0;
      chk("R8", "stop beats start", int'(phase), 0);
      chk("R7", "no evt when staying idle", int'(phase_evt), 0);

      // write while running is dropped (R9)
      wr(0, 5); wr(2, 1);
      start = 1'b1; @(negedge clk); start = 1'b0;
      repeat (3) @(negedge clk);
      wr(0, 12);
      do_stop();
      start = 1'b1; @(negedge clk); start = 1'b0;
      measure(hi, gap, evs);
      chk("R9", "start level after running write", hi, 5);
      do_stop();

      // write together with start is dropped (R9)
      cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 8'd9; start = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0; start = 1'b0;
      measure(hi, gap, evs);
      chk("R9", "start level with write at start", hi, 5);
      do_stop();
      start = 1'b1; @(negedge clk); start = 1'b0;
      measure(hi, gap, evs);
      chk("R9", "start level still old after restart", hi, 5);
      do_stop();

      // idle write is taken (R9)
      wr(0, 9);
      start = 1'b1; @(negedge clk); start = 1'b0;
      measure(hi, gap, evs);
      chk("R9", "idle write taken", hi, 9);
      do_stop();

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog (all requirements): actual %0d expected %0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule